// File: doc/BRIEF.md
# Miss Tracking Entry with Deferred Targets

This block is one outstanding-miss slot of a non-blocking cache. When a miss is taken, the slot records the block address, an order tag and a ready time. It then collects every request that hits the same block while the fill is outstanding. Requests are kept in a primary target queue. A request that cannot be satisfied by the fill already on its way goes to a second, deferred queue. That queue is replayed as a fresh miss after the primary targets retire. Each target holds a 4-bit command, a 2-bit source (0 = CPU, 1 = snoop, 2 = prefetcher), an ID, an order tag and a ready time.

Snoops from other agents can reach the slot while its own request is in flight. The slot decides whether a snoop precedes or follows its request. It queues snoops that must be replayed after the fill, and it drives the snoop response controls: inhibit, supply-exclusive, shared and handled. It also records that the coming fill will be invalidated or downgraded. When ownership is lost, it rewrites pending upgrade-style commands into full or failing forms.

Exactly one operation strobe is expected per cycle. If several are raised, the priority is allocate, deallocate, pop, mark-in-service, exclusive fill, promote, snoop, add. Command codes: 0 read, 1 read-exclusive, 2 upgrade, 3 SC-upgrade, 4 SC-upgrade-fail, 5 store-conditional, 6 store-conditional-fail, 7 write, 8 hardware prefetch, 9 invalidate. Codes 1 through 7 and 9 need exclusive ownership, and a snoop with such a code invalidates. The rewrite maps 2 to 1, 3 to 4 and 5 to 6, and leaves every other code unchanged.

Top module: `missEntry`

## Requirements
- R1: Allocate records address, order and ready time, clears in-service, pending-dirty, both post flags and downstream-pending, empties both queues and leaves exactly one primary target whose source is 2 when its command is 8 and 0 otherwise.
- R2: A primary or deferred push whose source is not 1 and whose command needs exclusive sets that queue's needs-exclusive flag (primNeedsExcl / defNeedsExcl).
- R3: An added target goes to the deferred queue when the entry is in service and the deferred queue is non-empty, post-invalidate is set, or the command needs exclusive while pending-dirty is clear, post-downgrade is set or the entry is a forward; otherwise it is appended to the primary queue.
- R4: A target deferred while post-invalidate is set is stored with its command rewritten (2 to 1, 3 to 4, 5 to 6).
- R5: Mark-in-service sets in-service, sets pending-dirty to primary needs-exclusive OR respPendingDirty, and clears post-invalidate and post-downgrade.
- R6: A snoop seen while not in service, or an express snoop while downstream-pending is set, reports unhandled, drives no response control and changes no flag; if its command needs exclusive, both queues are rewritten.
- R7: A snoop on an in-service entry whose post-invalidate is already set reports handled, queues nothing and drives no inhibit, supply-exclusive or shared; an exclusive-needing one rewrites the deferred queue.
- R8: Otherwise, when pending-dirty is set or the snoop invalidates, the snoop is appended to the primary queue with source 1; pending-dirty also drives inhibit and supply-exclusive, and an exclusive-needing snoop sets post-invalidate.
- R9: An in-service snoop without post-invalidate whose command needs no exclusive and is cacheable sets post-downgrade and drives shared; every in-service snoop reports handled.
- R10: Promote with an empty primary queue and a non-empty deferred queue moves the deferred targets and flags to the primary queue, takes the order tag of the new head and sets ready time to the larger of nowTime and the head's ready time; with a non-empty primary queue it does nothing.
- R11: An exclusive fill while the deferred queue needs exclusive and neither post flag is set appends all deferred targets to the primary queue, sets primary needs-exclusive and empties the deferred queue; otherwise it does nothing.
- R12: Each queue reports full and empty; a push or append beyond the depth is dropped and sets errSticky, which stays set until reset.
- R13: Pop removes the primary head in arrival order; deallocate with an empty primary queue clears busy, in-service and both queues, and with a non-empty primary queue it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nowTime | input | 16 | Current time |
| allocEn | input | 1 | Allocate the entry with the request payload |
| addEn | input | 1 | Add the request payload as a CPU target |
| snoopEn | input | 1 | Present the request payload as a snoop |
| markEn | input | 1 | Mark the request as issued |
| fillExclEn | input | 1 | An exclusive fill arrived |
| promoteEn | input | 1 | Promote deferred targets |
| popEn | input | 1 | Retire the primary head |
| deallocEn | input | 1 | Release the entry |
| reqAddr | input | ADDR_W | Block address on allocate |
| reqCmd | input | 4 | Command code |
| reqId | input | 4 | Target ID |
| reqOrder | input | 8 | Order tag |
| reqReady | input | 16 | Ready time of the target |
| reqForward | input | 1 | Allocate as a forward entry |
| reqExpress | input | 1 | Snoop is express |
| reqUncacheable | input | 1 | Snoop is uncacheable |
| respPendingDirty | input | 1 | Response will carry ownership (mark-in-service) |
| dsPendSet | input | 1 | Set downstream-pending |
| dsPendClr | input | 1 | Clear downstream-pending |
| busy | output | 1 | Entry allocated |
| inService | output | 1 | Request issued |
| pendingDirty | output | 1 | Ownership expected with the fill |
| postInvalidate | output | 1 | Fill will be invalidated by a later snoop |
| postDowngrade | output | 1 | Fill will be downgraded by a later snoop |
| dsPending | output | 1 | Downstream-pending flag |
| entryAddr | output | ADDR_W | Recorded block address |
| entryOrder | output | 8 | Recorded order tag |
| entryReady | output | 16 | Recorded ready time |
| headValid | output | 1 | Primary head present |
| headCmd | output | 4 | Primary head command |
| headSrc | output | 2 | Primary head source |
| headId | output | 4 | Primary head ID |
| primCount | output | CW | Primary queue occupancy |
| defCount | output | CW | Deferred queue occupancy |
| primFull | output | 1 | Primary queue full |
| primEmpty | output | 1 | Primary queue empty |
| defFull | output | 1 | Deferred queue full |
| defEmpty | output | 1 | Deferred queue empty |
| primNeedsExcl | output | 1 | Primary queue needs exclusive |
| defNeedsExcl | output | 1 | Deferred queue needs exclusive |
| snoopHandled | output | 1 | Snoop handled by this entry |
| snoopInhibit | output | 1 | Inhibit the memory response |
| snoopSupplyExcl | output | 1 | Supply the block exclusive |
| snoopShared | output | 1 | Assert shared |
| errSticky | output | 1 | A queue overflow occurred |

## Verification
The bench stresses the defer decision from several angles: a cacheable read snoop that sets post-downgrade, a deferred queue that is already non-empty, and an exclusive target added while pending-dirty is clear. A design that checks only one of these terms would place later targets on the wrong queue, and the scoreboard would see the wrong retirement order. It also drives an invalidating snoop into a full primary queue, which must be dropped and flagged. It adds an upgrade after post-invalidate is set, which must retire as read-exclusive; a missing rewrite would retire it as an upgrade. Snoops before issue and express snoops with downstream-pending set must stay silent. A snoop after post-invalidate must not queue again. A blocked exclusive fill must leave the deferred queue in place. Promote must take the later of the two times.

// File: rtl/missEntryPkg.sv
package missEntryPkg;
  localparam int CMD_W  = 4;
  localparam int ID_W   = 4;
  localparam int ORD_W  = 8;
  localparam int TIME_W = 16;

  localparam logic [CMD_W-1:0] CMD_READ            = 4'd0;
  localparam logic [CMD_W-1:0] CMD_READ_EX         = 4'd1;
  localparam logic [CMD_W-1:0] CMD_UPGRADE         = 4'd2;
  localparam logic [CMD_W-1:0] CMD_SC_UPGRADE      = 4'd3;
  localparam logic [CMD_W-1:0] CMD_SC_UPGRADE_FAIL = 4'd4;
  localparam logic [CMD_W-1:0] CMD_STORE_COND      = 4'd5;
  localparam logic [CMD_W-1:0] CMD_STORE_COND_FAIL = 4'd6;
  localparam logic [CMD_W-1:0] CMD_WRITE           = 4'd7;
  localparam logic [CMD_W-1:0] CMD_HW_PREFETCH     = 4'd8;
  localparam logic [CMD_W-1:0] CMD_INVALIDATE      = 4'd9;

  typedef enum logic [1:0] {SRC_CPU = 2'd0, SRC_SNOOP = 2'd1, SRC_PREFETCH = 2'd2} srcT;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    srcT               src;
    logic [ID_W-1:0]   id;
    logic [ORD_W-1:0]  order;
    logic [TIME_W-1:0] ready;
  } targetT;

  typedef struct packed {
    logic   primClear;
    logic   primRewrite;
    logic   primPop;
    logic   primAppend;
    logic   primTakeFlags;
    logic   primForceExcl;
    logic   primPush;
    targetT primItem;
    logic   defClear;
    logic   defRewrite;
    logic   defPush;
    targetT defItem;
  } strobeT;

  function automatic logic cmdNeedsExcl(logic [CMD_W-1:0] c);
    case (c)
      CMD_READ_EX, CMD_UPGRADE, CMD_SC_UPGRADE, CMD_SC_UPGRADE_FAIL,
      CMD_STORE_COND, CMD_STORE_COND_FAIL, CMD_WRITE, CMD_INVALIDATE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [CMD_W-1:0] cmdRewrite(logic [CMD_W-1:0] c);
    case (c)
      CMD_UPGRADE:    return CMD_READ_EX;
      CMD_SC_UPGRADE: return CMD_SC_UPGRADE_FAIL;
      CMD_STORE_COND: return CMD_STORE_COND_FAIL;
      default:        return c;
    endcase
  endfunction
endpackage

// File: rtl/missEntryData.sv
module missEntryData
  import missEntryPkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strb,
  output targetT              primHead,
  output logic [CW-1:0]       primCount,
  output logic [CW-1:0]       defCount,
  output logic                primExcl,
  output logic                defExcl,
  output logic [ORD_W-1:0]    defHeadOrder,
  output logic [TIME_W-1:0]   defHeadReady,
  output logic                overflow
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  targetT [DEPTH-1:0] primItems, defItems, pN, dN;
  logic [CW-1:0] pC, dC;
  logic pX, dX, pOvf, dOvf;

  // Primary queue: clear, rewrite, pop, append deferred, push, in that order
  always_comb begin
    pN = primItems; pC = primCount; pX = primExcl; pOvf = 1'b0;
    if (strb.primClear) begin pC = '0; pX = 1'b0; end
    if (strb.primRewrite)
      for (int i = 0; i < DEPTH; i++) pN[i].cmd = cmdRewrite(pN[i].cmd);
    if (strb.primPop && pC != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) pN[i] = pN[i+1];
      pC = pC - CW'(1);
    end
    if (strb.primAppend) begin
      if (strb.primTakeFlags) pX = defExcl;
      else if (strb.primForceExcl) pX = 1'b1;
      for (int j = 0; j < DEPTH; j++) begin
        if (CW'(j) < defCount) begin
          if (pC < FULL) begin
            pN[pC[IW-1:0]] = defItems[j];
            pC = pC + CW'(1);
          end else pOvf = 1'b1;
        end
      end
    end
    if (strb.primPush) begin
      if (pC < FULL) begin
        pN[pC[IW-1:0]] = strb.primItem;
        pC = pC + CW'(1);
        if (strb.primItem.src != SRC_SNOOP) pX = pX | cmdNeedsExcl(strb.primItem.cmd);
      end else pOvf = 1'b1;
    end
  end

  // Deferred queue: clear, rewrite, push
  always_comb begin
    dN = defItems; dC = defCount; dX = defExcl; dOvf = 1'b0;
    if (strb.defClear) begin dC = '0; dX = 1'b0; end
    if (strb.defRewrite)
      for (int i = 0; i < DEPTH; i++) dN[i].cmd = cmdRewrite(dN[i].cmd);
    if (strb.defPush) begin
      if (dC < FULL) begin
        dN[dC[IW-1:0]] = strb.defItem;
        dC = dC + CW'(1);
        if (strb.defItem.src != SRC_SNOOP) dX = dX | cmdNeedsExcl(strb.defItem.cmd);
      end else dOvf = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primItems <= '0; defItems <= '0;
      primCount <= '0; defCount <= '0;
      primExcl  <= 1'b0; defExcl <= 1'b0;
    end else begin
      primItems <= pN; defItems <= dN;
      primCount <= pC; defCount <= dC;
      primExcl  <= pX; defExcl  <= dX;
    end
  end

  assign primHead     = primItems[0];
  assign defHeadOrder = defItems[0].order;
  assign defHeadReady = defItems[0].ready;
  assign overflow     = pOvf | dOvf;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    primCount <= FULL && defCount <= FULL); // R12
  AST_PROMOTE_ONTO_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.primAppend && strb.primTakeFlags) |-> primCount == '0); // R10
  AST_FULL_PUSH_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.defPush && !strb.defClear && defCount == FULL) |=> defCount == FULL); // R12
endmodule

// File: rtl/missEntryCtrl.sv
module missEntryCtrl
  import missEntryPkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [TIME_W-1:0]   nowTime,
  input  logic                allocEn,
  input  logic                addEn,
  input  logic                snoopEn,
  input  logic                markEn,
  input  logic                fillExclEn,
  input  logic                promoteEn,
  input  logic                popEn,
  input  logic                deallocEn,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [CMD_W-1:0]    reqCmd,
  input  logic [ID_W-1:0]     reqId,
  input  logic [ORD_W-1:0]    reqOrder,
  input  logic [TIME_W-1:0]   reqReady,
  input  logic                reqForward,
  input  logic                reqExpress,
  input  logic                reqUncacheable,
  input  logic                respPendingDirty,
  input  logic                dsPendSet,
  input  logic                dsPendClr,
  input  logic [CW-1:0]       primCount,
  input  logic [CW-1:0]       defCount,
  input  logic                primExcl,
  input  logic                defExcl,
  input  logic [ORD_W-1:0]    defHeadOrder,
  input  logic [TIME_W-1:0]   defHeadReady,
  input  logic                overflow,
  output strobeT              strb,
  output logic                busy,
  output logic                inService,
  output logic                pendingDirty,
  output logic                postInvalidate,
  output logic                postDowngrade,
  output logic                dsPending,
  output logic [ADDR_W-1:0]   entryAddr,
  output logic [ORD_W-1:0]    entryOrder,
  output logic [TIME_W-1:0]   entryReady,
  output logic                snoopHandled,
  output logic                snoopInhibit,
  output logic                snoopSupplyExcl,
  output logic                snoopShared,
  output logic                errSticky
);
  typedef enum logic [3:0] {OP_NONE, OP_ALLOC, OP_DEALLOC, OP_POP, OP_MARK,
                            OP_FILL, OP_PROMOTE, OP_SNOOP, OP_ADD} opT;
  opT op;
  logic isForward;

  function automatic targetT mkItem(logic [CMD_W-1:0] c, srcT s, logic [ID_W-1:0] i,
                                    logic [ORD_W-1:0] o, logic [TIME_W-1:0] r);
    targetT t;
    t.cmd = c; t.src = s; t.id = i; t.order = o; t.ready = r;
    return t;
  endfunction

  always_comb begin
    if (allocEn)         op = OP_ALLOC;
    else if (deallocEn)  op = OP_DEALLOC;
    else if (popEn)      op = OP_POP;
    else if (markEn)     op = OP_MARK;
    else if (fillExclEn) op = OP_FILL;
    else if (promoteEn)  op = OP_PROMOTE;
    else if (snoopEn)    op = OP_SNOOP;
    else if (addEn)      op = OP_ADD;
    else                 op = OP_NONE;
  end

  logic reqExcl, snoopEarly, snoopQueue, snoopDown, addDefer, fillOk, promoteOk, deallocOk;
  assign reqExcl    = cmdNeedsExcl(reqCmd);
  assign snoopEarly = !inService || (reqExpress && dsPending);
  assign snoopQueue = !snoopEarly && !postInvalidate && (pendingDirty || reqExcl);
  assign snoopDown  = !snoopEarly && !postInvalidate && !reqExcl && !reqUncacheable;
  assign addDefer   = inService && (defCount != '0 || postInvalidate ||
                      (reqExcl && (!pendingDirty || postDowngrade || isForward)));
  assign fillOk     = defExcl && !postInvalidate && !postDowngrade;
  assign promoteOk  = primCount == '0 && defCount != '0;
  assign deallocOk  = primCount == '0;

  always_comb begin
    strb = '0;
    snoopHandled = 1'b0; snoopInhibit = 1'b0; snoopSupplyExcl = 1'b0; snoopShared = 1'b0;
    case (op)
      OP_ALLOC: begin
        strb.primClear = 1'b1; strb.defClear = 1'b1; strb.primPush = 1'b1;
        strb.primItem = mkItem(reqCmd, (reqCmd == CMD_HW_PREFETCH) ? SRC_PREFETCH : SRC_CPU,
                               reqId, reqOrder, reqReady);
      end
      OP_DEALLOC: if (deallocOk) begin strb.primClear = 1'b1; strb.defClear = 1'b1; end
      OP_POP: strb.primPop = 1'b1;
      OP_FILL: if (fillOk) begin
        strb.primAppend = 1'b1; strb.primForceExcl = 1'b1; strb.defClear = 1'b1;
      end
      OP_PROMOTE: if (promoteOk) begin
        strb.primAppend = 1'b1; strb.primTakeFlags = 1'b1; strb.defClear = 1'b1;
      end
      OP_SNOOP: begin
        strb.defRewrite  = reqExcl;
        strb.primRewrite = reqExcl && snoopEarly;
        strb.primPush    = snoopQueue;
        strb.primItem    = mkItem(reqCmd, SRC_SNOOP, reqId, reqOrder, nowTime);
        snoopHandled     = !snoopEarly;
        snoopInhibit     = snoopQueue && pendingDirty;
        snoopSupplyExcl  = snoopQueue && pendingDirty;
        snoopShared      = snoopDown;
      end
      OP_ADD: begin
        strb.defPush  = addDefer;
        strb.primPush = !addDefer;
        strb.defItem  = mkItem(postInvalidate ? cmdRewrite(reqCmd) : reqCmd, SRC_CPU,
                               reqId, reqOrder, reqReady);
        strb.primItem = mkItem(reqCmd, SRC_CPU, reqId, reqOrder, reqReady);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; inService <= 1'b0; pendingDirty <= 1'b0;
      postInvalidate <= 1'b0; postDowngrade <= 1'b0; dsPending <= 1'b0;
      isForward <= 1'b0; entryAddr <= '0; entryOrder <= '0; entryReady <= '0;
      errSticky <= 1'b0;
    end else begin
      if (overflow) errSticky <= 1'b1;
      if (dsPendSet) dsPending <= 1'b1;
      else if (dsPendClr) dsPending <= 1'b0;
      case (op)
        OP_ALLOC: begin
          busy <= 1'b1; inService <= 1'b0; pendingDirty <= 1'b0;
          postInvalidate <= 1'b0; postDowngrade <= 1'b0; dsPending <= 1'b0;
          isForward <= reqForward; entryAddr <= reqAddr;
          entryOrder <= reqOrder; entryReady <= reqReady;
        end
        OP_DEALLOC: if (deallocOk) begin busy <= 1'b0; inService <= 1'b0; end
        OP_MARK: begin
          inService <= 1'b1; pendingDirty <= primExcl | respPendingDirty;
          postInvalidate <= 1'b0; postDowngrade <= 1'b0;
        end
        OP_PROMOTE: if (promoteOk) begin
          entryOrder <= defHeadOrder;
          entryReady <= (nowTime > defHeadReady) ? nowTime : defHeadReady;
        end
        OP_SNOOP: begin
          if (snoopQueue && reqExcl) postInvalidate <= 1'b1;
          if (snoopDown) postDowngrade <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_MARK_SETS_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    op == OP_MARK |=> inService && !postInvalidate && !postDowngrade); // R5
  AST_INHIBIT_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    snoopInhibit |-> inService && pendingDirty && snoopHandled); // R8
  AST_SHARED_ONLY_READS: assert property (@(posedge clk) disable iff (!rstN)
    snoopShared |-> !cmdNeedsExcl(reqCmd) && !reqUncacheable && inService); // R9
  AST_EARLY_SNOOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (op == OP_SNOOP && !inService) |=> $stable(postInvalidate) && $stable(postDowngrade)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky); // R12
endmodule

// File: rtl/missEntry.sv
module missEntry
  import missEntryPkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [TIME_W-1:0]   nowTime,
  input  logic                allocEn,
  input  logic                addEn,
  input  logic                snoopEn,
  input  logic                markEn,
  input  logic                fillExclEn,
  input  logic                promoteEn,
  input  logic                popEn,
  input  logic                deallocEn,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [CMD_W-1:0]    reqCmd,
  input  logic [ID_W-1:0]     reqId,
  input  logic [ORD_W-1:0]    reqOrder,
  input  logic [TIME_W-1:0]   reqReady,
  input  logic                reqForward,
  input  logic                reqExpress,
  input  logic                reqUncacheable,
  input  logic                respPendingDirty,
  input  logic                dsPendSet,
  input  logic                dsPendClr,
  output logic                busy,
  output logic                inService,
  output logic                pendingDirty,
  output logic                postInvalidate,
  output logic                postDowngrade,
  output logic                dsPending,
  output logic [ADDR_W-1:0]   entryAddr,
  output logic [ORD_W-1:0]    entryOrder,
  output logic [TIME_W-1:0]   entryReady,
  output logic                headValid,
  output logic [CMD_W-1:0]    headCmd,
  output logic [1:0]          headSrc,
  output logic [ID_W-1:0]     headId,
  output logic [CW-1:0]       primCount,
  output logic [CW-1:0]       defCount,
  output logic                primFull,
  output logic                primEmpty,
  output logic                defFull,
  output logic                defEmpty,
  output logic                primNeedsExcl,
  output logic                defNeedsExcl,
  output logic                snoopHandled,
  output logic                snoopInhibit,
  output logic                snoopSupplyExcl,
  output logic                snoopShared,
  output logic                errSticky
);
  strobeT strb;
  targetT primHead;
  logic [ORD_W-1:0]  defHeadOrder;
  logic [TIME_W-1:0] defHeadReady;
  logic overflow;

  missEntryCtrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rstN, .nowTime, .allocEn, .addEn, .snoopEn, .markEn, .fillExclEn,
    .promoteEn, .popEn, .deallocEn, .reqAddr, .reqCmd, .reqId, .reqOrder, .reqReady,
    .reqForward, .reqExpress, .reqUncacheable, .respPendingDirty, .dsPendSet, .dsPendClr,
    .primCount, .defCount, .primExcl(primNeedsExcl), .defExcl(defNeedsExcl),
    .defHeadOrder, .defHeadReady, .overflow, .strb, .busy, .inService, .pendingDirty,
    .postInvalidate, .postDowngrade, .dsPending, .entryAddr, .entryOrder, .entryReady,
    .snoopHandled, .snoopInhibit, .snoopSupplyExcl, .snoopShared, .errSticky
  );

  missEntryData #(.DEPTH(DEPTH)) u_data (
    .clk, .rstN, .strb, .primHead, .primCount, .defCount,
    .primExcl(primNeedsExcl), .defExcl(defNeedsExcl),
    .defHeadOrder, .defHeadReady, .overflow
  );

  assign headValid = primCount != '0;
  assign headCmd   = primHead.cmd;
  assign headSrc   = primHead.src;
  assign headId    = primHead.id;
  assign primFull  = primCount == CW'(DEPTH);
  assign primEmpty = primCount == '0;
  assign defFull   = defCount == CW'(DEPTH);
  assign defEmpty  = defCount == '0;

  AST_ALLOC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    allocEn |=> primCount == CW'(1) && defCount == '0 && !inService); // R1
  AST_DEALLOC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (deallocEn && !allocEn && primEmpty) |=> !busy && !inService && defEmpty); // R13
endmodule

// File: tb/missEntry_bench.sv
module missEntry_bench;
  import missEntryPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] nowTime = '0;
  logic allocEn = 0, addEn = 0, snoopEn = 0, markEn = 0, fillExclEn = 0;
  logic promoteEn = 0, popEn = 0, deallocEn = 0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqCmd = '0, reqId = '0;
  logic [7:0]  reqOrder = '0;
  logic [15:0] reqReady = '0;
  logic reqForward = 0, reqExpress = 0, reqUncacheable = 0, respPendingDirty = 0;
  logic dsPendSet = 0, dsPendClr = 0;
  logic busy, inService, pendingDirty, postInvalidate, postDowngrade, dsPending;
  logic [31:0] entryAddr;
  logic [7:0]  entryOrder;
  logic [15:0] entryReady;
  logic headValid;
  logic [3:0] headCmd, headId;
  logic [1:0] headSrc;
  logic [2:0] primCount, defCount;
  logic primFull, primEmpty, defFull, defEmpty, primNeedsExcl, defNeedsExcl;
  logic snoopHandled, snoopInhibit, snoopSupplyExcl, snoopShared, errSticky;

  int checks = 0;
  int errors = 0;
  logic [9:0] expQ[$];

  always #5 clk = ~clk;

  missEntry u_missEntry (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    allocEn = 0; addEn = 0; snoopEn = 0; markEn = 0; fillExclEn = 0;
    promoteEn = 0; popEn = 0; deallocEn = 0; dsPendSet = 0; dsPendClr = 0;
    reqExpress = 0; reqUncacheable = 0; reqForward = 0; respPendingDirty = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; clearIn();
  endtask

  task automatic setReq(logic [3:0] c, logic [3:0] i, logic [7:0] o, logic [15:0] r);
    reqCmd = c; reqId = i; reqOrder = o; reqReady = r;
  endtask

  task automatic expectHead(logic [3:0] c, logic [1:0] s, logic [3:0] i);
    expQ.push_back({c, s, i});
  endtask

  task automatic drain(int n);
    for (int k = 0; k < n; k++) begin popEn = 1; tick(); end
  endtask

  // Monitor: each pop compares the current head against the scoreboard (R13)
  always @(negedge clk) begin
    if (rstN && popEn && !allocEn && !deallocEn) begin
      if (expQ.size() == 0) chk("R13 unexpected pop", {headCmd, headSrc, headId}, 10'h3ff);
      else chk("R13 head order", {22'd0, headCmd, headSrc, headId}, {22'd0, expQ.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    chk("R13 reset busy", busy, 0);
    chk("R12 reset empty", {primEmpty, defEmpty, errSticky}, 3'b110);

    // Scenario A
    reqAddr = 32'h1234; setReq(CMD_READ, 1, 5, 10); allocEn = 1; tick();
    chk("R1 alloc state", {busy, inService, primCount}, {1'b1, 1'b0, 3'd1});
    chk("R1 alloc addr", entryAddr, 32'h1234);
    chk("R1 alloc order/ready", {entryOrder, entryReady}, {8'd5, 16'd10});
    chk("R1 alloc head", {headCmd, headSrc, headId}, {CMD_READ, 2'd0, 4'd1});
    setReq(CMD_UPGRADE, 2, 6, 11); addEn = 1; tick();
    chk("R2 primary excl", {primNeedsExcl, primCount}, {1'b1, 3'd2});
    markEn = 1; tick();
    chk("R5 mark", {inService, pendingDirty}, 2'b11);
    setReq(CMD_READ, 7, 7, 0); nowTime = 12; snoopEn = 1; #1;
    chk("R8 R9 snoop ctl", {snoopHandled, snoopInhibit, snoopSupplyExcl, snoopShared}, 4'b1111);
    tick();
    chk("R9 post downgrade", {postDowngrade, postInvalidate, primCount}, {2'b10, 3'd3});
    setReq(CMD_READ, 3, 8, 13); addEn = 1; tick();
    chk("R3 read to primary", {primCount, primFull, defCount}, {3'd4, 1'b1, 3'd0});
    setReq(CMD_WRITE, 4, 20, 30); addEn = 1; tick();
    chk("R3 excl after downgrade defers", {defCount, defNeedsExcl}, {3'd1, 1'b1});
    setReq(CMD_READ, 5, 21, 31); addEn = 1; tick();
    chk("R3 defer behind deferred", defCount, 2);
    setReq(CMD_INVALIDATE, 12, 9, 0); snoopEn = 1; #1;
    chk("R8 inval snoop ctl", {snoopHandled, snoopInhibit, snoopShared}, 3'b110);
    tick();
    chk("R12 overflow dropped", {primCount, errSticky, postInvalidate}, {3'd4, 2'b11});
    setReq(CMD_UPGRADE, 6, 22, 32); addEn = 1; tick();
    chk("R4 defer after invalidate", defCount, 3);
    setReq(CMD_READ, 13, 10, 0); snoopEn = 1; #1;
    chk("R7 snoop after invalidate", {snoopHandled, snoopInhibit, snoopSupplyExcl, snoopShared}, 4'b1000);
    tick();
    chk("R7 nothing queued", primCount, 4);
    fillExclEn = 1; tick();
    chk("R11 fill blocked", {primCount, defCount}, {3'd4, 3'd3});
    deallocEn = 1; tick();
    chk("R13 dealloc ignored", {busy, inService}, 2'b11);
    expectHead(CMD_READ, 0, 1); expectHead(CMD_UPGRADE, 0, 2);
    expectHead(CMD_READ, 1, 7); expectHead(CMD_READ, 0, 3);
    drain(4);
    chk("R13 drained", primEmpty, 1);
    nowTime = 50; promoteEn = 1; tick();
    chk("R10 promote counts", {primCount, defEmpty, primNeedsExcl}, {3'd3, 2'b11});
    chk("R10 promote order/ready", {entryOrder, entryReady}, {8'd20, 16'd50});
    promoteEn = 1; tick();
    chk("R10 promote ignored when primary busy", {primCount, entryOrder}, {3'd3, 8'd20});
    expectHead(CMD_WRITE, 0, 4); expectHead(CMD_READ, 0, 5); expectHead(CMD_READ_EX, 0, 6);
    drain(3);
    deallocEn = 1; tick();
    chk("R13 dealloc", {busy, inService, errSticky}, 3'b001);

    // Scenario B: snoop before issue
    setReq(CMD_HW_PREFETCH, 8, 1, 2); allocEn = 1; tick();
    chk("R1 prefetch source", headSrc, 2);
    setReq(CMD_STORE_COND, 9, 2, 3); addEn = 1; tick();
    setReq(CMD_READ_EX, 1, 3, 0); snoopEn = 1; #1;
    chk("R6 early snoop ctl", {snoopHandled, snoopInhibit, snoopSupplyExcl, snoopShared}, 4'b0000);
    tick();
    chk("R6 early snoop state", {primCount, postInvalidate, postDowngrade}, {3'd2, 2'b00});
    expectHead(CMD_HW_PREFETCH, 2, 8); expectHead(CMD_STORE_COND_FAIL, 0, 9);
    drain(2);
    deallocEn = 1; tick();

    // Scenario C: exclusive fill and express snoop
    setReq(CMD_READ, 10, 4, 5); allocEn = 1; tick();
    markEn = 1; tick();
    chk("R5 mark without ownership", {inService, pendingDirty}, 2'b10);
    setReq(CMD_READ_EX, 11, 5, 6); addEn = 1; tick();
    chk("R3 excl without dirty defers", {primCount, defCount, defNeedsExcl}, {3'd1, 3'd1, 1'b1});
    fillExclEn = 1; tick();
    chk("R11 fill merges", {primCount, defEmpty, primNeedsExcl}, {3'd2, 2'b11});
    dsPendSet = 1; tick();
    setReq(CMD_READ, 2, 6, 0); snoopEn = 1; reqExpress = 1; #1;
    chk("R6 express snoop ctl", {snoopHandled, snoopShared}, 2'b00);
    tick();
    chk("R6 express snoop state", postDowngrade, 0);
    setReq(CMD_READ_EX, 12, 7, 0); snoopEn = 1; reqUncacheable = 1; #1;
    chk("R8 clean inval snoop ctl", {snoopHandled, snoopInhibit, snoopShared}, 3'b100);
    tick();
    chk("R8 clean inval state", {primCount, postInvalidate}, {3'd3, 1'b1});
    expectHead(CMD_READ, 0, 10); expectHead(CMD_READ_EX, 0, 11); expectHead(CMD_READ_EX, 1, 12);
    drain(3);
    chk("R13 scoreboard empty", expQ.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule